// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the write cycles that a host issues to a parallel NOR-style flash device and turns the recognised multi-write command sequences into one-clock start pulses for the program and erase engines behind it. Each host write arrives as an address, a data byte and a one-cycle write enable. A correct sequence ends with exactly one pulse on the matching start output. The address and data of the final write travel alongside the pulse and stay held until the next command.

Two unlock writes open every normal command. After them, either a program command follows, or an erase setup is followed by a second unlock pair and a chip-erase or sector-erase code. A write that does not fit the expected next step discards the partial sequence. A separate unlock-bypass mode shortens programming to two writes and accepts nothing else except its own two-write exit. The mode is entered either by command or by holding the acceleration input high. While the external erase-busy input is high, every write is dropped and the decoder state is frozen. The synchronous reset acts as the hardware reset and returns the decoder to read mode at once.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, or after reset is applied in any mode, all three start outputs are 0 and bypass_active is 0 (read mode).
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by any address and data, produce prog_start in the cycle after the fourth write, with cmd_addr and cmd_data equal to that write's address and data. Unlock addresses are compared on address bits 10:0 only.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and 10h@555h produce chip_erase_start in the cycle after the sixth write.
- R4: The same five-write prefix followed by 30h at any address produces sector_erase_start, with cmd_addr equal to that sixth write's address.
- R5: A write that does not match the expected next step returns the decoder to read mode without any pulse. A following complete sequence is accepted normally.
- R6: The writes AAh@555h, 55h@2AAh and 20h@555h enter bypass mode, and bypass_active reads 1.
- R7: In bypass mode, A0h at any address followed by any write produces prog_start with that second write's address and data. Every other write, including unlock and erase codes, produces no pulse and leaves the mode unchanged.
- R8: In bypass mode, 90h at any address followed by 00h leaves bypass mode. 90h followed by any other data keeps bypass mode.
- R9: While accel_in is 1, bypass_active is 1 and the two-write bypass program is accepted. A falling edge of accel_in returns the decoder to read mode.
- R10: While erase_busy is 1, writes are ignored: no pulse is produced and the partial sequence or mode in progress is kept as it was.
- R11: Each start pulse lasts exactly one clock. cmd_addr and cmd_data stay unchanged until the next start pulse.
- R12: At most one start output is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | One host write in this cycle |
| wr_addr | input | ADDR_W (21) | Write address |
| wr_data | input | 8 | Write data byte |
| accel_in | input | 1 | Acceleration request; forces bypass mode while high |
| erase_busy | input | 1 | Erase in progress; writes are ignored |
| prog_start | output | 1 | One-cycle program start |
| chip_erase_start | output | 1 | One-cycle chip erase start |
| sector_erase_start | output | 1 | One-cycle sector erase start |
| cmd_addr | output | ADDR_W (21) | Address of the command's final write |
| cmd_data | output | 8 | Data of the command's final write |
| bypass_active | output | 1 | Decoder is in unlock-bypass mode |

## Verification
The main function is driven with the three complete normal sequences and with sequences broken at the second and at the sixth write. This shows that matching depends on every step and that an abort leaves no residue behind. The same unlock and erase codes are then sent inside bypass mode, which shows that the decode depends on the mode and not on the byte values alone. The two exit data values show that only 00h confirms the exit. A partial sequence with a foreign write injected while erase_busy is high shows that the state is held, and not reset, across the busy window.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CMD_W = 8;
    localparam int KEY_W = 11;

    localparam logic [KEY_W-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 11'h2AA;

    localparam logic [CMD_W-1:0] KEY_DATA_A     = 8'hAA;
    localparam logic [CMD_W-1:0] KEY_DATA_B     = 8'h55;
    localparam logic [CMD_W-1:0] OP_SETUP       = 8'h80;
    localparam logic [CMD_W-1:0] OP_CHIP        = 8'h10;
    localparam logic [CMD_W-1:0] OP_SECTOR      = 8'h30;
    localparam logic [CMD_W-1:0] OP_BYP_ENTER   = 8'h20;
    localparam logic [CMD_W-1:0] OP_PROG        = 8'hA0;
    localparam logic [CMD_W-1:0] OP_BYP_LEAVE   = 8'h90;
    localparam logic [CMD_W-1:0] OP_BYP_CONFIRM = 8'h00;

    typedef enum logic [3:0] {
        ST_READ,
        ST_KEY1,
        ST_KEY2,
        ST_PGM_ARM,
        ST_ERS_SETUP,
        ST_ERS_KEY1,
        ST_ERS_KEY2,
        ST_BYP,
        ST_BYP_PGM,
        ST_BYP_LEAVE
    } seq_state_t;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_PROG,
        CMD_CHIP,
        CMD_SECTOR
    } cmd_kind_t;

    typedef struct packed {
        logic key_a;
        logic key_b;
        logic prog_at_key;
        logic setup;
        logic chip;
        logic sector;
        logic byp_enter;
        logic prog_any;
        logic leave_any;
        logic confirm;
    } write_class_t;

    function automatic logic in_bypass(input seq_state_t s);
        return (s == ST_BYP) || (s == ST_BYP_PGM) || (s == ST_BYP_LEAVE);
    endfunction

    function automatic logic keyed(input logic [KEY_W-1:0] a, input logic [CMD_W-1:0] d,
                                   input logic [KEY_W-1:0] ka, input logic [CMD_W-1:0] kd);
        return (a == ka) && (d == kd);
    endfunction

endpackage

// File: rtl/fcd_write_classifier.sv
module fcd_write_classifier
    import flash_cmd_pkg::*;
(
    input  logic [KEY_W-1:0] key_addr,
    input  logic [CMD_W-1:0] data,
    output write_class_t     wc
);
    always_comb begin
        wc             = '0;
        wc.key_a       = keyed(key_addr, data, KEY_ADDR_A, KEY_DATA_A);
        wc.key_b       = keyed(key_addr, data, KEY_ADDR_B, KEY_DATA_B);
        wc.prog_at_key = keyed(key_addr, data, KEY_ADDR_A, OP_PROG);
        wc.setup       = keyed(key_addr, data, KEY_ADDR_A, OP_SETUP);
        wc.chip        = keyed(key_addr, data, KEY_ADDR_A, OP_CHIP);
        wc.byp_enter   = keyed(key_addr, data, KEY_ADDR_A, OP_BYP_ENTER);
        wc.sector      = (data == OP_SECTOR);
        wc.prog_any    = (data == OP_PROG);
        wc.leave_any   = (data == OP_BYP_LEAVE);
        wc.confirm     = (data == OP_BYP_CONFIRM);
    end

    always_comb begin
        a_r12_class_exclusive: assert ($countones({wc.key_a, wc.key_b, wc.setup, wc.chip, wc.byp_enter, wc.prog_at_key}) <= 1);
    end
endmodule

// File: rtl/fcd_sequencer.sv
module fcd_sequencer
    import flash_cmd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         erase_busy,
    input  logic         accel_in,
    input  write_class_t wc,
    output cmd_kind_t    issue,
    output logic         bypass_active
);
    seq_state_t state_q, cur, state_d;
    logic       accel_q;
    logic       accel_fall;
    logic       take;

    assign accel_fall = accel_q && !accel_in;
    assign take       = wr_en && !erase_busy;

    always_comb begin
        if (accel_in && !in_bypass(state_q)) cur = ST_BYP;
        else                                  cur = state_q;
    end

    assign bypass_active = in_bypass(cur);

    always_comb begin
        state_d = cur;
        issue   = CMD_NONE;
        if (accel_fall) begin
            state_d = ST_READ;
        end else if (take) begin
            unique case (cur)
                ST_READ:      state_d = wc.key_a ? ST_KEY1 : ST_READ;
                ST_KEY1:      state_d = wc.key_b ? ST_KEY2 : ST_READ;
                ST_KEY2: begin
                    if (wc.prog_at_key)    state_d = ST_PGM_ARM;
                    else if (wc.setup)     state_d = ST_ERS_SETUP;
                    else if (wc.byp_enter) state_d = ST_BYP;
                    else                   state_d = ST_READ;
                end
                ST_PGM_ARM: begin
                    issue   = CMD_PROG;
                    state_d = ST_READ;
                end
                ST_ERS_SETUP: state_d = wc.key_a ? ST_ERS_KEY1 : ST_READ;
                ST_ERS_KEY1:  state_d = wc.key_b ? ST_ERS_KEY2 : ST_READ;
                ST_ERS_KEY2: begin
                    if (wc.chip)        issue = CMD_CHIP;
                    else if (wc.sector) issue = CMD_SECTOR;
                    state_d = ST_READ;
                end
                ST_BYP: begin
                    if (wc.prog_any)       state_d = ST_BYP_PGM;
                    else if (wc.leave_any) state_d = ST_BYP_LEAVE;
                    else                   state_d = ST_BYP;
                end
                ST_BYP_PGM: begin
                    issue   = CMD_PROG;
                    state_d = ST_BYP;
                end
                ST_BYP_LEAVE: state_d = wc.confirm ? ST_READ : ST_BYP;
                default:      state_d = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READ;
            accel_q <= 1'b0;
        end else begin
            state_q <= state_d;
            accel_q <= accel_in;
        end
    end

    // R7: bypass mode never launches an erase
    a_r7_bypass_no_erase: assert property (@(posedge clk) disable iff (rst)
        in_bypass(cur) |-> (issue != CMD_CHIP) && (issue != CMD_SECTOR));

    // R9: a falling acceleration edge always lands in read mode
    a_r9_accel_release: assert property (@(posedge clk) disable iff (rst)
        (accel_q && !accel_in) |=> (state_q == ST_READ));
endmodule

// File: rtl/fcd_launch_reg.sv
module fcd_launch_reg
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_kind_t         issue,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CMD_W-1:0]  wr_data,
    output logic              prog_start,
    output logic              chip_erase_start,
    output logic              sector_erase_start,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CMD_W-1:0]  cmd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prog_start         <= 1'b0;
            chip_erase_start   <= 1'b0;
            sector_erase_start <= 1'b0;
            cmd_addr           <= '0;
            cmd_data           <= '0;
        end else begin
            prog_start         <= (issue == CMD_PROG);
            chip_erase_start   <= (issue == CMD_CHIP);
            sector_erase_start <= (issue == CMD_SECTOR);
            if (issue != CMD_NONE) begin
                cmd_addr <= wr_addr;
                cmd_data <= wr_data;
            end
        end
    end

    // R12: one start at a time
    a_r12_onehot_start: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_start, chip_erase_start, sector_erase_start}));

    // R11: pulses are one clock wide, payload held between commands
    a_r11_prog_single: assert property (@(posedge clk) disable iff (rst)
        prog_start |=> !prog_start);
    a_r11_chip_single: assert property (@(posedge clk) disable iff (rst)
        chip_erase_start |=> !chip_erase_start);
    a_r11_payload_hold: assert property (@(posedge clk) disable iff (rst)
        !(prog_start || chip_erase_start || sector_erase_start) |-> $stable(cmd_addr));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              accel_in,
    input  logic              erase_busy,
    output logic              prog_start,
    output logic              chip_erase_start,
    output logic              sector_erase_start,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data,
    output logic              bypass_active
);
    write_class_t wc;
    cmd_kind_t    issue;

    fcd_write_classifier u_class (
        .key_addr (wr_addr[KEY_W-1:0]),
        .data     (wr_data),
        .wc       (wc)
    );

    fcd_sequencer u_seq (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .erase_busy    (erase_busy),
        .accel_in      (accel_in),
        .wc            (wc),
        .issue         (issue),
        .bypass_active (bypass_active)
    );

    fcd_launch_reg #(.ADDR_W(ADDR_W)) u_launch (
        .clk                (clk),
        .rst                (rst),
        .issue              (issue),
        .wr_addr            (wr_addr),
        .wr_data            (wr_data),
        .prog_start         (prog_start),
        .chip_erase_start   (chip_erase_start),
        .sector_erase_start (sector_erase_start),
        .cmd_addr           (cmd_addr),
        .cmd_data           (cmd_data)
    );

    // R10: a busy cycle never yields a start in the next cycle
    a_r10_busy_silent: assert property (@(posedge clk) disable iff (rst)
        erase_busy |=> !(prog_start || chip_erase_start || sector_erase_start));

    // R4: sector start carries the address of the final write
    a_r4_sector_addr: assert property (@(posedge clk) disable iff (rst)
        sector_erase_start |-> (cmd_addr == $past(wr_addr)));

    // R3: chip start follows a chip-erase code write
    a_r3_chip_code: assert property (@(posedge clk) disable iff (rst)
        chip_erase_start |-> ($past(wr_data) == OP_CHIP) && $past(wr_en));
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          accel_in = 1'b0;
    logic          erase_busy = 1'b0;
    logic          prog_start, chip_erase_start, sector_erase_start, bypass_active;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    cmd_data;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .accel_in(accel_in), .erase_busy(erase_busy),
        .prog_start(prog_start), .chip_erase_start(chip_erase_start),
        .sector_erase_start(sector_erase_start), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .bypass_active(bypass_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        pulses += int'(prog_start) + int'(chip_erase_start) + int'(sector_erase_start);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #1;
        pulses += int'(prog_start) + int'(chip_erase_start) + int'(sector_erase_start);
    endtask

    task automatic unlock();
        wr(21'h555, 8'hAA);
        wr(21'h2AA, 8'h55);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        chk("R1 prog_start after reset", prog_start, 0);
        chk("R1 chip_erase_start after reset", chip_erase_start, 0);
        chk("R1 sector_erase_start after reset", sector_erase_start, 0);
        chk("R1 bypass_active after reset", bypass_active, 0);
    endtask

    task automatic t_program();
        pulses = 0;
        unlock();
        wr(21'h555, 8'hA0);
        wr(21'h1F00D, 8'h3C);
        chk("R2 prog_start", prog_start, 1);
        chk("R2 cmd_addr", cmd_addr, 21'h1F00D);
        chk("R2 cmd_data", cmd_data, 8'h3C);
        chk("R12 no chip with prog", chip_erase_start, 0);
        idle();
        chk("R11 prog_start width", prog_start, 0);
        chk("R11 cmd_addr held", cmd_addr, 21'h1F00D);
        chk("R11 pulse count", pulses, 1);
    endtask

    task automatic t_chip();
        pulses = 0;
        unlock(); wr(21'h555, 8'h80); unlock();
        wr(21'h555, 8'h10);
        chk("R3 chip_erase_start", chip_erase_start, 1);
        chk("R12 no sector with chip", sector_erase_start, 0);
        idle();
        chk("R3 single pulse", pulses, 1);
    endtask

    task automatic t_sector();
        pulses = 0;
        unlock(); wr(21'h555, 8'h80); unlock();
        wr(21'h1AB00, 8'h30);
        chk("R4 sector_erase_start", sector_erase_start, 1);
        chk("R4 cmd_addr", cmd_addr, 21'h1AB00);
        idle();
        chk("R4 single pulse", pulses, 1);
    endtask

    task automatic t_abort();
        pulses = 0;
        wr(21'h555, 8'hAA); wr(21'h2AB, 8'h55); wr(21'h555, 8'hA0); wr(21'h00100, 8'h11);
        unlock(); wr(21'h555, 8'h80); unlock(); wr(21'h555, 8'h20);
        idle();
        chk("R5 broken sequences give no pulse", pulses, 0);
        chk("R5 no bypass after abort", bypass_active, 0);
        unlock(); wr(21'h555, 8'hA0); wr(21'h00200, 8'h22);
        chk("R5 sequence after abort accepted", prog_start, 1);
        idle();
    endtask

    task automatic t_bypass();
        pulses = 0;
        unlock(); wr(21'h555, 8'h20);
        chk("R6 bypass_active", bypass_active, 1);
        unlock(); wr(21'h555, 8'h80); unlock(); wr(21'h555, 8'h10);
        idle();
        chk("R7 foreign writes give no pulse", pulses, 0);
        chk("R7 bypass kept", bypass_active, 1);
        wr(21'h0ABCD, 8'hA0); wr(21'h12345, 8'h5A);
        chk("R7 bypass prog_start", prog_start, 1);
        chk("R7 bypass cmd_addr", cmd_addr, 21'h12345);
        chk("R7 bypass cmd_data", cmd_data, 8'h5A);
        wr(21'h00000, 8'h90); wr(21'h00000, 8'h11);
        idle();
        chk("R8 exit needs 00h", bypass_active, 1);
        wr(21'h10000, 8'h90); wr(21'h00000, 8'h00);
        chk("R8 exit done", bypass_active, 0);
        idle();
        unlock(); wr(21'h555, 8'hA0); wr(21'h00300, 8'h33);
        chk("R8 normal program after exit", prog_start, 1);
        idle();
    endtask

    task automatic t_accel();
        @(negedge clk); accel_in = 1'b1;
        @(posedge clk); #1;
        chk("R9 accel forces bypass", bypass_active, 1);
        wr(21'h00000, 8'hA0); wr(21'h0F0F0, 8'h77);
        chk("R9 accel prog_start", prog_start, 1);
        chk("R9 accel cmd_data", cmd_data, 8'h77);
        idle();
        @(negedge clk); accel_in = 1'b0;
        @(posedge clk); #1;
        chk("R9 release returns to read mode", bypass_active, 0);
    endtask

    task automatic t_busy();
        pulses = 0;
        wr(21'h555, 8'hAA);
        @(negedge clk); erase_busy = 1'b1; wr_addr = 21'h333; wr_data = 8'h12;
        @(posedge clk); #1;
        unlock(); wr(21'h555, 8'h80); unlock(); wr(21'h555, 8'h10);
        @(negedge clk); erase_busy = 1'b0; wr_en = 1'b0;
        @(posedge clk); #1;
        chk("R10 no pulse while busy", pulses, 0);
        wr(21'h2AA, 8'h55); wr(21'h555, 8'hA0); wr(21'h00400, 8'h44);
        chk("R10 partial sequence held across busy", prog_start, 1);
        chk("R10 cmd_addr", cmd_addr, 21'h00400);
        idle();
    endtask

    task automatic t_hw_reset();
        unlock(); wr(21'h555, 8'h20);
        do_reset();
        chk("R1 reset leaves bypass", bypass_active, 0);
        chk("R1 reset clears payload", cmd_addr, 0);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_program();
        t_chip();
        t_sector();
        t_abort();
        t_bypass();
        t_accel();
        t_busy();
        t_hw_reset();
        done = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end
endmodule